// File: doc/BRIEF.md
# Dual-Path Bus Transceiver with Transparent, Held and Edge-Captured Storage

This block links two bidirectional buses, called the A side and the B side, through two independent storage paths: one carries A toward B, the other carries B toward A. Every path owns a register that can follow its source (pass mode), keep its contents (hold mode), or take a new sample when its own port clock falls (capture mode). A separate enable decides whether the path drives its destination bus or leaves it released. The A-to-B enable is active high and the B-to-A enable is active low.

The design runs on one fast system clock. Each external port clock passes through a chain of synchronizer flops, and a falling edge is found by comparing the newest synchronized sample with the one before it. The mode inputs and enables are taken as synchronous to the system clock. Each bus is a resolved inout, and each side also reports its drive enable as a plain output. A synchronous reset models the power-up state: it releases both buses and clears both registers. When both enables are active, both buses are driven at the same time. The block does not arbitrate this case.

Top module: `dual_bus_xcvr`

## Requirements
- R1: Each path is WIDTH bits wide (default 18), and every bit position is carried independently. A capture or pass on one path leaves the other path's register unchanged.
- R2: With a path's latch enable high, its register loads the source bus on every system clock edge. The destination bus therefore shows the source value one system cycle later.
- R3: With the latch enable low and the port clock steady, the register keeps its value while the source bus changes.
- R4: With the latch enable low, a high-to-low transition of the port clock captures the source bus. The new value appears on the destination bus on the third system clock edge after the transition, and not on the second.
- R5: A low-to-high transition of the port clock does not change the register.
- R6: The A-to-B drive enable is active high. When it is 1 the B bus is driven from the A-to-B register; when it is 0, b_drive_en is 0 and the B bus is released.
- R7: The B-to-A drive enable is active low. When it is 0 the A bus is driven from the B-to-A register; when it is 1, a_drive_en is 0 and the A bus is released.
- R8: When the latch enable falls with no port clock edge, the register keeps the last value it loaded while in pass mode. If pass mode and a falling port clock edge occur in the same cycle, pass mode wins.
- R9: When both drive enables are active together, a_drive_en and b_drive_en are both 1, and each bus carries its own register value.
- R10: While rst is 1, both drive enables are 0 regardless of the enable inputs, and both registers clear to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| a_bus | inout | WIDTH | A-side bus: source of the A-to-B path, destination of the B-to-A path |
| b_bus | inout | WIDTH | B-side bus: source of the B-to-A path, destination of the A-to-B path |
| ab_le | input | 1 | A-to-B latch enable, high selects pass mode |
| ab_pclk | input | 1 | A-to-B port clock, asynchronous, captures on its falling edge |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high selects pass mode |
| ba_pclk | input | 1 | B-to-A port clock, asynchronous, captures on its falling edge |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| a_drive_en | output | 1 | 1 when the block drives the A bus |
| b_drive_en | output | 1 | 1 when the block drives the B bus |

## Verification
Both paths are driven by a seeded random sequence of pass, capture and hold operations with random data, plus directed all-ones and single-edge-bit patterns. The random mix tells apart a path that merely follows its source from one that really keeps its value once the latch enable drops. Capture is sampled both one cycle before and exactly at the expected synchronizer latency, which catches an edge detector that fires on the wrong polarity or at the wrong stage. Directed cases cover rising port clock edges, opposite enable polarities, a mid-run reset, and the state where both buses are driven at once. The bench flags that last case as contention.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      PATH_HOLD    = 2'd0,
      PATH_PASS    = 2'd1,
      PATH_CAPTURE = 2'd2
   } path_mode_e;

   // Pass mode takes priority over a captured edge in the same cycle.
   function automatic path_mode_e pick_mode(input logic le, input logic fall);
      if (le)        return PATH_PASS;
      else if (fall) return PATH_CAPTURE;
      else           return PATH_HOLD;
   endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic fall_pulse
);
   localparam int CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("xcvr_edge_sync: STAGES must be at least 2");
   end

   logic [CHAIN-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[CHAIN-2:0], async_in};
   end

   // chain_q[STAGES-1] is the synchronized sample, chain_q[STAGES] the previous one
   assign fall_pulse = chain_q[STAGES] & ~chain_q[STAGES-1];

   // R4: one falling edge yields a single-cycle pulse
   assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
      fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/xcvr_path_store.sv
module xcvr_path_store
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             le,
   input  logic             fall,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_path_store: WIDTH must be positive");
   end

   path_mode_e mode;
   assign mode = pick_mode(le, fall);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         unique case (mode)
            PATH_PASS, PATH_CAPTURE: q <= din;
            default:                 q <= q;
         endcase
      end
   end

   // R2: pass mode loads the source every cycle
   assert_pass_loads_R2: assert property (@(posedge clk) disable iff (rst)
      le |=> q == $past(din));

   // R3: no enable and no edge keeps the value
   assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (rst)
      (!le && !fall) |=> q == $past(q));

   // R4: a detected falling edge captures the source
   assert_edge_captures_R4: assert property (@(posedge clk) disable iff (rst)
      (!le && fall) |=> q == $past(din));

endmodule

// File: rtl/xcvr_port_gate.sv
module xcvr_port_gate #(
   parameter bit OE_ACTIVE_LOW = 1'b0
) (
   input  logic rst,
   input  logic oe_pin,
   output logic drive_en
);
   logic oe_asserted;

   if (OE_ACTIVE_LOW) begin : g_low
      assign oe_asserted = ~oe_pin;
   end else begin : g_high
      assign oe_asserted = oe_pin;
   end

   // reset stands in for power-up: buses released
   assign drive_en = oe_asserted & ~rst;

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
   parameter int WIDTH       = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   inout  wire  [WIDTH-1:0] a_bus,
   inout  wire  [WIDTH-1:0] b_bus,
   input  logic             ab_le,
   input  logic             ab_pclk,
   input  logic             ab_oe,
   input  logic             ba_le,
   input  logic             ba_pclk,
   input  logic             ba_oe_n,
   output logic             a_drive_en,
   output logic             b_drive_en
);
   localparam logic [WIDTH-1:0] RELEASED = {WIDTH{1'bz}};

   if (WIDTH < 1) begin : g_bad_width
      $error("dual_bus_xcvr: WIDTH must be positive");
   end

   logic             ab_fall, ba_fall;
   logic [WIDTH-1:0] ab_q, ba_q;

   // A toward B
   xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_ab_sync (
      .clk(clk), .rst(rst), .async_in(ab_pclk), .fall_pulse(ab_fall));

   xcvr_path_store #(.WIDTH(WIDTH)) u_ab_store (
      .clk(clk), .rst(rst), .le(ab_le), .fall(ab_fall), .din(a_bus), .q(ab_q));

   xcvr_port_gate #(.OE_ACTIVE_LOW(1'b0)) u_ab_gate (
      .rst(rst), .oe_pin(ab_oe), .drive_en(b_drive_en));

   // B toward A
   xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_ba_sync (
      .clk(clk), .rst(rst), .async_in(ba_pclk), .fall_pulse(ba_fall));

   xcvr_path_store #(.WIDTH(WIDTH)) u_ba_store (
      .clk(clk), .rst(rst), .le(ba_le), .fall(ba_fall), .din(b_bus), .q(ba_q));

   xcvr_port_gate #(.OE_ACTIVE_LOW(1'b1)) u_ba_gate (
      .rst(rst), .oe_pin(ba_oe_n), .drive_en(a_drive_en));

   // three-state drivers onto the resolved buses
   assign b_bus = b_drive_en ? ab_q : RELEASED;
   assign a_bus = a_drive_en ? ba_q : RELEASED;

endmodule

// File: tb/dual_bus_xcvr_tb.sv
module dual_bus_xcvr_tb;
   localparam int W = 18;
   localparam logic [W-1:0] MASK = {W{1'b1}};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ab_le = 0, ab_pclk = 0, ab_oe = 0;
   logic ba_le = 0, ba_pclk = 0, ba_oe_n = 1;
   logic a_drive_en, b_drive_en;

   logic         tb_a_en = 0, tb_b_en = 0;
   logic [W-1:0] tb_a_val = '0, tb_b_val = '0;
   wire  [W-1:0] a_bus, b_bus;
   assign a_bus = tb_a_en ? tb_a_val : {W{1'bz}};
   assign b_bus = tb_b_en ? tb_b_val : {W{1'bz}};

   int checks = 0, errors = 0, contention_seen = 0;
   bit done = 0;
   logic [W-1:0] exp_ab = '0, exp_ba = '0;

   always #4 clk = ~clk;   // 125 MHz

   dual_bus_xcvr #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus),
      .ab_le(ab_le), .ab_pclk(ab_pclk), .ab_oe(ab_oe),
      .ba_le(ba_le), .ba_pclk(ba_pclk), .ba_oe_n(ba_oe_n),
      .a_drive_en(a_drive_en), .b_drive_en(b_drive_en));

   // expected drive enable from the requirement polarity (R6, R7, R10)
   function automatic logic exp_drive(input logic r, input logic pin, input logic act_low);
      return !r && (act_low ? !pin : pin);
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   // dir 0: A toward B (tb drives A, reads B); dir 1: B toward A
   task automatic set_dir(input int dir);
      if (dir == 0) begin
         ba_oe_n = 1; ab_oe = 1; tb_b_en = 0; tb_a_en = 1;
      end else begin
         ab_oe = 0; ba_oe_n = 0; tb_a_en = 0; tb_b_en = 1;
      end
   endtask

   task automatic drive_src(input int dir, input logic [W-1:0] v);
      if (dir == 0) tb_a_val = v; else tb_b_val = v;
   endtask

   function automatic logic [W-1:0] read_dst(input int dir);
      return (dir == 0) ? b_bus : a_bus;
   endfunction

   task automatic set_le(input int dir, input logic v);
      if (dir == 0) ab_le = v; else ba_le = v;
   endtask

   task automatic set_pclk(input int dir, input logic v);
      if (dir == 0) ab_pclk = v; else ba_pclk = v;
   endtask

   function automatic logic get_pclk(input int dir);
      return (dir == 0) ? ab_pclk : ba_pclk;
   endfunction

   task automatic set_exp(input int dir, input logic [W-1:0] v);
      if (dir == 0) exp_ab = v; else exp_ba = v;
   endtask

   function automatic logic [W-1:0] get_exp(input int dir);
      return (dir == 0) ? exp_ab : exp_ba;
   endfunction

   // R2 pass, then R8 keep the last passed value after the enable falls
   task automatic op_pass(input int dir, input logic [W-1:0] d);
      set_dir(dir);
      set_le(dir, 1); drive_src(dir, d);
      step(1);
      check("R2 pass", read_dst(dir), d);
      set_exp(dir, d);
      set_le(dir, 0);
      step(1);
      drive_src(dir, ~d & MASK);
      step(3);
      check("R8 keep last pass", read_dst(dir), d);
   endtask

   // R4 capture on falling port clock, latency three edges
   task automatic op_capture(input int dir, input logic [W-1:0] d);
      set_dir(dir);
      set_le(dir, 0);
      set_pclk(dir, 1);
      step(3);
      drive_src(dir, d);
      step(1);
      set_pclk(dir, 0);
      step(2);
      check("R4 not yet captured", read_dst(dir), get_exp(dir));
      step(1);
      check("R4 captured", read_dst(dir), d);
      set_exp(dir, d);
   endtask

   // R3 hold with steady clock, R5 rising edge ignored
   task automatic op_hold(input int dir, input logic [W-1:0] d);
      set_dir(dir);
      set_le(dir, 0);
      drive_src(dir, d);
      step(2);
      if (get_pclk(dir) == 1'b0) begin
         set_pclk(dir, 1);
         step(4);
         check("R5 rising edge ignored", read_dst(dir), get_exp(dir));
      end else begin
         step(4);
         check("R3 hold", read_dst(dir), get_exp(dir));
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00c0ffee));
      // R10: reset releases both buses even with enables active
      ab_oe = 1; ba_oe_n = 0;
      step(3);
      check("R10 reset b released", {{(W-1){1'b0}}, b_drive_en}, '0);
      check("R10 reset a released", {{(W-1){1'b0}}, a_drive_en}, '0);
      ab_oe = 0; ba_oe_n = 1;
      rst = 0;
      step(1);
      // R6, R7 polarity of enables
      check("R6 ab_oe low releases", {{(W-1){1'b0}}, b_drive_en},
            {{(W-1){1'b0}}, exp_drive(rst, ab_oe, 1'b0)});
      check("R7 ba_oe_n high releases", {{(W-1){1'b0}}, a_drive_en},
            {{(W-1){1'b0}}, exp_drive(rst, ba_oe_n, 1'b1)});
      set_dir(0);
      step(1);
      check("R6 ab_oe high drives", {{(W-1){1'b0}}, b_drive_en}, 1);
      check("R10 ab cleared", b_bus, '0);
      set_dir(1);
      step(1);
      check("R7 ba_oe_n low drives", {{(W-1){1'b0}}, a_drive_en}, 1);
      check("R10 ba cleared", a_bus, '0);

      // R1 full width patterns
      op_pass(0, MASK);
      op_capture(0, 18'h20001);
      op_pass(1, 18'h15555);
      op_capture(1, 18'h2AAAA);
      // R1 independence: ab untouched by ba work
      set_dir(0); tb_a_val = exp_ab;
      step(1);
      check("R1 ab independent", b_bus, 18'h20001);

      // R8: pass and falling edge same cycle, pass wins
      set_dir(0);
      ab_le = 0; ab_pclk = 1; step(3);
      ab_le = 1; tb_a_val = 18'h0F0F0; ab_pclk = 0;
      step(2);
      tb_a_val = 18'h30303;
      step(2);
      check("R8 pass over edge", b_bus, 18'h30303);
      ab_le = 0; exp_ab = 18'h30303;
      step(1);

      // constrained random mix
      for (int i = 0; i < 60; i++) begin
         int dir = int'($urandom % 2);
         int op  = int'($urandom % 3);
         logic [W-1:0] d = W'($urandom) & MASK;
         case (op)
            0: op_pass(dir, d);
            1: op_capture(dir, d);
            default: op_hold(dir, d);
         endcase
      end

      // R9 contention: both enables active, neither side driven by bench
      tb_a_en = 0; tb_b_en = 0;
      ab_le = 0; ba_le = 0;
      ab_oe = 1; ba_oe_n = 0;
      step(1);
      if (a_drive_en && b_drive_en) begin
         contention_seen++;
         $display("note: contention, both buses driven by the block");
      end
      check("R9 contention flagged", W'(contention_seen), 1);
      check("R9 b carries ab store", b_bus, exp_ab);

      // R10 mid-run reset clears storage
      ab_oe = 0; ba_oe_n = 1;
      rst = 1; step(2); rst = 0;
      set_dir(0); tb_a_val = 18'h11111;
      step(1);
      check("R10 mid reset clears", b_bus, '0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule